// File: doc/BRIEF.md
# D-Channel Serial Buffer with Byte-Period Interrupt

This block sits on a framed time-division serial link and handles the low-rate signalling channel carried in the first bit cells of every frame. On the receive side it shifts the signalling bits of each frame into a shift register. Once per byte period it copies the last eight received bits into a read register and raises an interrupt. A processor then reads that register, and writes the next outgoing byte, through one register address (0x04). On the transmit side the block reloads a transmit shift register from the write register at the start of each byte period and drives its bits into the signalling cells of the next frames. If nothing new was written, the last byte is sent again.

Two rates are supported. At the fast rate, two bits per frame are carried in cells 0 and 1, and a byte period is four frames. At the slow rate, one bit per frame is carried in cell 0, and a byte period is eight frames. The bit clock is presented as a one-cycle strobe in the system clock domain, and each strobe opens a new bit cell. The frame pulse is sampled together with the strobe that opens cell 0. The high-impedance drivers of the serial output and of the interrupt pin are left to the pad ring. The block supplies an enable for each of them.

Two state machines run the block. The frame timer machine starts in SYNC_HUNT. It takes the transition HUNT_TO_LOCK into SYNC_LOCK on the first frame pulse and then stays in SYNC_LOCK until reset. The interrupt machine starts in IRQ_IDLE. It takes RAISE into IRQ_PEND at the interrupt cell of a reference frame. It takes CLEAR_ACCESS back to IRQ_IDLE on a read or write of address 0x04, or CLEAR_FRAME back to IRQ_IDLE on the next frame pulse. A raise in the same cycle as a clear keeps the machine in IRQ_PEND (HOLD).

Top module: `dch_buffer`

## Requirements
- R1: In fast mode (`slow_rate`=0), the bits in cells 0 and 1 of every frame are captured. After reference frame n, `reg_rdata` with `reg_addr`=0x04 returns the two bits of frame n-3 in bits 7:6, those of frame n-2 in bits 5:4, those of frame n-1 in bits 3:2 and those of frame n in bits 1:0. In each pair the cell 0 bit sits in the higher position. With any other address, `reg_rdata` is 0.
- R2: In slow mode (`slow_rate`=1), only cell 0 is captured. After reference frame n, bit 7 holds the bit of frame n-7 and bit 0 holds the bit of frame n.
- R3: Frames are numbered from 0, starting at the first frame pulse after reset. A reference frame has index 3 mod 4 in fast mode, or 7 mod 8 in slow mode. `irq` rises one clock after the bit strobe that opens cell 2 (fast mode) or cell 1 (slow mode) of a reference frame.
- R4: `irq` falls one clock after a read or write strobe to address 0x04, or one clock after the frame-pulse strobe, whichever comes first. An access to any other address leaves `irq` unchanged.
- R5: In fast mode, a byte written to 0x04 during reference frame n is driven on `dout` as bits 7:6 in cells 0 and 1 of frame n+1, then 5:4 in frame n+2, 3:2 in frame n+3 and 1:0 in frame n+4. The higher bit is sent first. Each bit is valid from the clock after the strobe that opens its cell.
- R6: In slow mode, a byte written during reference frame n is driven one bit per frame in cell 0: bit 7 in frame n+1 through bit 0 in frame n+8.
- R7: If no write occurs, the same byte is sent again in every following byte period.
- R8: Reset sets the write register to 0xFF, so every signalling cell carries 1 until the first write. Reset also holds `irq` and `dout_oe` low.
- R9: With `chan_en`=1, `dout_oe` is high exactly during the signalling cells and `irq_oe` is high. With `chan_en`=0, `dout_oe` and `irq_oe` are low, but reception continues and the read register still updates.
- R10: A write to 0x04 in the same cycle as the frame-pulse strobe that starts a byte period is sent in that byte period. A write made after that strobe is first sent in the following byte period.
- R11: Before the first frame pulse after reset, no cell is treated as a signalling cell: `dout_oe` and `irq` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_stb | input | 1 | One-cycle strobe opening each bit cell |
| frame_pulse | input | 1 | Frame start, sampled with the strobe opening cell 0 |
| rxd | input | 1 | Serial receive data, sampled at the strobe that closes a cell |
| dout | output | 1 | Serial transmit data for the signalling cells |
| dout_oe | output | 1 | Output enable for `dout` |
| irq | output | 1 | Byte-period interrupt, high while pending |
| irq_oe | output | 1 | Output enable for `irq` |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (read register when the address is 0x04) |
| slow_rate | input | 1 | 1 selects one bit per frame, 0 selects two bits per frame |
| chan_en | input | 1 | Enables the transmit timeslot and the interrupt output |

## Verification
Two functions can meet in one cycle: a processor write to 0x04 and the frame-pulse strobe that reloads the transmit shift register. The bench drives a write strobe in the exact cycle of that frame pulse. It expects the new byte in the cells that start in the same cycle, and it pops each bit from its scoreboard to compare. It also writes just after a reload strobe and expects the old byte for one more byte period before the new one appears. The interrupt also has two clear sources that compete: a register access and the frame pulse. The bench covers the access path, the frame-pulse path and an access to a foreign address, in separate reference frames.

// File: rtl/dch_pkg.sv
package dch_pkg;

    typedef enum logic {
        SYNC_HUNT,
        SYNC_LOCK
    } sync_state_t;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PEND
    } irq_state_t;

endpackage

// File: rtl/dch_frame_timer.sv
module dch_frame_timer
    import dch_pkg::*;
#(
    parameter int FRAME_CELLS = 256,
    parameter int BYTE_BITS   = 8,
    localparam int CELL_W     = $clog2(FRAME_CELLS),
    localparam int FCNT_W     = $clog2(BYTE_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              frame_pulse,
    input  logic              slow_rate,
    output logic              locked,
    output logic [CELL_W-1:0] cell_q,
    output logic [CELL_W-1:0] dcells,
    output logic              frame_start,
    output logic              load_tx,
    output logic              d_sample,
    output logic              next_is_d,
    output logic              ref_frame,
    output logic              irq_point
);

    localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(FRAME_CELLS - 1);
    localparam logic [FCNT_W-1:0] FR_SLOW   = FCNT_W'(BYTE_BITS - 1);
    localparam logic [FCNT_W-1:0] FR_FAST   = FCNT_W'(BYTE_BITS / 2 - 1);

    sync_state_t       sync_q, sync_d;
    logic [FCNT_W-1:0] fidx_q, fidx_d, fr_last;
    logic [CELL_W-1:0] cell_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= SYNC_HUNT;
        else        sync_q <= sync_d;
    end

    // transitions: HUNT_TO_LOCK on the first frame pulse
    always_comb begin
        sync_d = sync_q;
        unique case (sync_q)
            SYNC_HUNT: if (bit_stb && frame_pulse) sync_d = SYNC_LOCK;
            SYNC_LOCK: sync_d = SYNC_LOCK;
        endcase
    end

    // outputs
    always_comb begin
        locked      = (sync_q == SYNC_LOCK);
        dcells      = slow_rate ? CELL_W'(1) : CELL_W'(2);
        fr_last     = slow_rate ? FR_SLOW : FR_FAST;
        frame_start = bit_stb && frame_pulse;
        if (frame_pulse)             cell_d = '0;
        else if (cell_q == CELL_LAST) cell_d = cell_q;
        else                          cell_d = cell_q + CELL_W'(1);
        ref_frame   = locked && (fidx_q >= fr_last);
        fidx_d      = (!locked || fidx_q >= fr_last) ? '0 : fidx_q + FCNT_W'(1);
        load_tx     = frame_start && (!locked || fidx_q >= fr_last);
        d_sample    = bit_stb && locked && (cell_q < dcells);
        next_is_d   = (locked || frame_start) && (cell_d < dcells);
        irq_point   = bit_stb && !frame_pulse && ref_frame && (cell_d == dcells);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
            fidx_q <= '0;
        end else if (bit_stb) begin
            if (locked || frame_pulse) cell_q <= cell_d;
            if (frame_pulse)           fidx_q <= fidx_d;
        end
    end

endmodule

// File: rtl/dch_rx_path.sv
module dch_rx_path #(
    parameter int BYTE_BITS = 8,
    parameter int CELL_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 d_sample,
    input  logic                 capture,
    input  logic                 frame_start,
    input  logic [CELL_W-1:0]    dcells,
    output logic [BYTE_BITS-1:0] rd_byte
);

    logic [BYTE_BITS-1:0] sr_q, sr_next;
    logic [2:0]           samp_cnt;

    assign sr_next = {sr_q[BYTE_BITS-2:0], rxd};

    // data registers carry no reset: contents are undefined until filled
    always_ff @(posedge clk) begin
        if (d_sample) sr_q <= sr_next;
        if (capture)  rd_byte <= sr_next;
    end

    // per-frame sample counter for the checker below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           samp_cnt <= '0;
        else if (frame_start) samp_cnt <= '0;
        else if (d_sample)    samp_cnt <= samp_cnt + 3'd1;
    end

    // R1 R2: never more samples in a frame than signalling cells
    assert_samples_per_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        {5'd0, samp_cnt} <= 8'(dcells));

endmodule

// File: rtl/dch_tx_path.sv
module dch_tx_path #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 load_tx,
    input  logic                 next_is_d,
    input  logic                 wr_hit,
    input  logic [BYTE_BITS-1:0] wdata,
    output logic                 dout_q,
    output logic                 oe_q
);

    logic [BYTE_BITS-1:0] wr_q, wr_next, tx_sr, src;

    always_comb begin
        wr_next = wr_hit ? wdata : wr_q;
        src     = load_tx ? wr_next : tx_sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '1;
            tx_sr  <= '1;
            dout_q <= 1'b1;
            oe_q   <= 1'b0;
        end else begin
            wr_q <= wr_next;
            if (launch) begin
                oe_q <= next_is_d;
                if (next_is_d) begin
                    dout_q <= src[BYTE_BITS-1];
                    tx_sr  <= {src[BYTE_BITS-2:0], 1'b1};
                end else if (load_tx) begin
                    tx_sr <= src;
                end
            end
        end
    end

endmodule

// File: rtl/dch_buffer.sv
module dch_buffer
    import dch_pkg::*;
#(
    parameter int               FRAME_CELLS = 256,
    parameter int               BYTE_BITS   = 8,
    parameter int               ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h04,
    localparam int              CELL_W      = $clog2(FRAME_CELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 frame_pulse,
    input  logic                 rxd,
    output logic                 dout,
    output logic                 dout_oe,
    output logic                 irq,
    output logic                 irq_oe,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [BYTE_BITS-1:0] reg_wdata,
    output logic [BYTE_BITS-1:0] reg_rdata,
    input  logic                 slow_rate,
    input  logic                 chan_en
);

    logic              locked, frame_start, load_tx, d_sample, next_is_d;
    logic              ref_frame, irq_point, dout_q, oe_q, acc_hit, wr_hit;
    logic [CELL_W-1:0] cell_q, dcells;
    logic [BYTE_BITS-1:0] rd_byte;
    irq_state_t        irq_q, irq_d;

    dch_frame_timer #(.FRAME_CELLS(FRAME_CELLS), .BYTE_BITS(BYTE_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_pulse(frame_pulse),
        .slow_rate(slow_rate), .locked(locked), .cell_q(cell_q), .dcells(dcells),
        .frame_start(frame_start), .load_tx(load_tx), .d_sample(d_sample),
        .next_is_d(next_is_d), .ref_frame(ref_frame), .irq_point(irq_point)
    );

    dch_rx_path #(.BYTE_BITS(BYTE_BITS), .CELL_W(CELL_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .d_sample(d_sample), .capture(irq_point),
        .frame_start(frame_start), .dcells(dcells), .rd_byte(rd_byte)
    );

    dch_tx_path #(.BYTE_BITS(BYTE_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .launch(bit_stb), .load_tx(load_tx),
        .next_is_d(next_is_d), .wr_hit(wr_hit), .wdata(reg_wdata),
        .dout_q(dout_q), .oe_q(oe_q)
    );

    assign acc_hit = (reg_rd || reg_wr) && (reg_addr == REG_ADDR);
    assign wr_hit  = reg_wr && (reg_addr == REG_ADDR);

    // interrupt state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= IRQ_IDLE;
        else        irq_q <= irq_d;
    end

    // transitions: RAISE, HOLD, CLEAR_ACCESS, CLEAR_FRAME
    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_IDLE: if (irq_point) irq_d = IRQ_PEND;
            IRQ_PEND: begin
                if (irq_point)                     irq_d = IRQ_PEND;
                else if (acc_hit || frame_start)   irq_d = IRQ_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        irq       = (irq_q == IRQ_PEND);
        irq_oe    = chan_en;
        dout      = dout_q;
        dout_oe   = oe_q && chan_en;
        reg_rdata = (reg_addr == REG_ADDR) ? rd_byte : '0;
    end

    // R3: the interrupt rises only in the interrupt cell of a reference frame
    assert_irq_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ref_frame && cell_q == dcells));

    // R4: an access to the register address clears a pending interrupt
    assert_irq_access_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && acc_hit && !irq_point) |=> !irq);

    // R4: the next frame pulse clears a pending interrupt
    assert_irq_frame_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && frame_start) |=> !irq);

    // R9: the transmit timeslot is driven only in signalling cells while enabled
    assert_oe_dcell_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (chan_en && cell_q < dcells));

    // R11: nothing is driven before frame alignment
    assert_quiet_hunt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!dout_oe && !irq));

endmodule

// File: tb/dch_buffer_bench.sv
module dch_buffer_bench;

    localparam int CELLS = 32;
    localparam int A_NONE = 0, A_RW = 1, A_RD = 2, A_PULSE_WR = 3, A_LATE_WR = 4, A_OTHER_WR = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_stb = 1'b0, frame_pulse = 1'b0, rxd = 1'b0;
    logic dout, dout_oe, irq, irq_oe;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
    logic reg_rd = 1'b0, reg_wr = 1'b0, slow_rate = 1'b0, chan_en = 1'b1;

    int checks = 0, fails = 0;
    bit mon_on = 0, tb_locked = 0, irq_exp = 0, wrote = 0;
    int tb_cell = 0;
    logic [7:0] cur_wr = 8'hFF;
    bit exp_tx[$];
    string tag_q[$];

    always #10 clk = ~clk;

    dch_buffer #(.FRAME_CELLS(CELLS)) u_dch_buffer (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_pulse(frame_pulse), .rxd(rxd),
        .dout(dout), .dout_oe(dout_oe), .irq(irq), .irq_oe(irq_oe), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slow_rate(slow_rate), .chan_en(chan_en)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit rxpat(int f, int c);
        return ((f * 37 + c * 11 + 5) % 7) > 2;
    endfunction

    function automatic logic [7:0] exp_read(int n, bit slow);
        logic [7:0] b = 8'h00;
        if (slow) begin
            for (int k = 7; k >= 0; k--) b = {b[6:0], rxpat(n - k, 0)};
        end else begin
            for (int k = 3; k >= 0; k--) begin
                b = {b[6:0], rxpat(n - k, 0)};
                b = {b[6:0], rxpat(n - k, 1)};
            end
        end
        return b;
    endfunction

    // monitor: samples mid-high-phase of each strobe cycle
    always @(posedge clk) begin
        #5;
        if (mon_on && bit_stb) begin
            int dc;
            bit exp_oe, b;
            string tg;
            dc = slow_rate ? 1 : 2;
            exp_oe = tb_locked && chan_en && (tb_cell < dc);
            check(dout_oe == exp_oe, tb_locked ? "R9" : "R11", "dout_oe", dout_oe, exp_oe);
            check(irq == irq_exp, tb_locked ? "R3/R4" : "R11", "irq", irq, irq_exp);
            check(irq_oe == chan_en, "R9", "irq_oe", irq_oe, chan_en);
            if (tb_locked && tb_cell < dc) begin
                if (exp_tx.size() == 0) begin
                    check(0, "R5", "scoreboard empty", 0, 1);
                end else begin
                    b = exp_tx.pop_front();
                    tg = tag_q.pop_front();
                    if (chan_en) check(dout == b, tg, "dout", dout, b);
                end
            end
        end
    end

    task automatic do_reset(bit slow);
        mon_on = 0;
        rst_n = 1'b0;
        slow_rate = slow;
        chan_en = 1'b1;
        exp_tx.delete();
        tag_q.delete();
        irq_exp = 0; tb_locked = 0; wrote = 0; cur_wr = 8'hFF;
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R8", "irq in reset", irq, 0);
        check(dout_oe == 1'b0, "R8", "dout_oe in reset", dout_oe, 0);
        rst_n = 1'b1;
        mon_on = 1;
        // strobes without a frame pulse: still unaligned
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); bit_stb = 1'b1; rxd = 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
    endtask

    task automatic run_frame(int f, int act, logic [7:0] val);
        int per, dc;
        bit is_ref, late;
        string tg;
        per = slow_rate ? 8 : 4;
        dc = slow_rate ? 1 : 2;
        is_ref = (f % per) == per - 1;
        for (int c = 0; c < CELLS; c++) begin
            @(negedge clk);
            bit_stb = 1'b1;
            frame_pulse = (c == 0);
            if (c == 0) begin
                irq_exp = 0;
                tb_locked = 1;
                if (act == A_PULSE_WR) begin
                    reg_addr = 8'h04; reg_wr = 1'b1; reg_wdata = val;
                    cur_wr = val; wrote = 1;
                end
                if (f % per == 0) begin
                    if (f == 0) tg = "R8";
                    else if (act == A_PULSE_WR) tg = "R10";
                    else if (!wrote) tg = "R7";
                    else tg = slow_rate ? "R6" : "R5";
                    for (int i = 7; i >= 0; i--) begin
                        exp_tx.push_back(cur_wr[i]);
                        tag_q.push_back(tg);
                    end
                    wrote = 0;
                end
            end
            if (is_ref && c == dc) irq_exp = 1;
            tb_cell = c;
            @(negedge clk);
            bit_stb = 1'b0; frame_pulse = 1'b0;
            reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 8'h00;
            rxd = rxpat(f, c);
            if (c == 3 && act != A_NONE && act != A_PULSE_WR) begin
                late = !irq_exp;
                if (act == A_OTHER_WR) begin
                    reg_addr = 8'h05; reg_wr = 1'b1; reg_wdata = 8'h00;
                end else begin
                    if (late) $display("NOTE late access in frame %0d: no integrity guarantee", f);
                    reg_addr = 8'h04;
                    irq_exp = 0;
                    if (act == A_RW || act == A_RD) begin
                        reg_rd = 1'b1;
                        #1;
                        check(reg_rdata == exp_read(f, slow_rate),
                              !chan_en ? "R9" : (slow_rate ? "R2" : "R1"),
                              "read byte", reg_rdata, exp_read(f, slow_rate));
                    end
                    if (act == A_RW || act == A_LATE_WR) begin
                        reg_wr = 1'b1; reg_wdata = val;
                        cur_wr = val; wrote = 1;
                    end
                end
            end
            if (c == 4 && f == 0) begin
                reg_addr = 8'h07;
                #1;
                check(reg_rdata == 8'h00, "R1", "foreign address read", reg_rdata, 0);
                reg_addr = 8'h00;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // fast mode
        do_reset(1'b0);
        for (int f = 0; f < 40; f++) begin
            int act;
            logic [7:0] v;
            act = A_NONE; v = 8'h00;
            chan_en = !(f >= 28 && f < 36);
            case (f)
                3:  begin act = A_RW;       v = 8'hA5; end
                11: act = A_RD;
                16: begin act = A_PULSE_WR; v = 8'h3C; end
                20: begin act = A_LATE_WR;  v = 8'h81; end
                23: act = A_OTHER_WR;
                31: act = A_RD;
                35: begin act = A_RW;       v = 8'h96; end
                default: act = A_NONE;
            endcase
            run_frame(f, act, v);
        end
        // slow mode
        do_reset(1'b1);
        for (int f = 0; f < 25; f++) begin
            int act;
            act = A_NONE;
            if (f == 7) act = A_RW;
            if (f == 15) act = A_RD;
            run_frame(f, act, 8'h5A);
        end
        mon_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule